// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a serial-bus protocol engine and a byte-addressed nonvolatile array. It collects the data bytes of one write transaction in a one-page staging buffer, then commits them to the array in a single wide write request when the transaction ends. After the commit it holds a busy flag for a fixed, self-timed programming window. While that window is open it ignores every request.

The protocol engine loads a start address and then strobes data bytes. Each byte lands at the pointer's offset within the page. Only the offset field advances, so bytes past the end of the page wrap to its start and overwrite what was buffered there earlier. Per-byte valid flags make sure only received bytes reach the array. A write-protect input suppresses bytes aimed at the protected upper region. An end strobe with nothing buffered, as in the address-only write that comes before a random read, starts no programming.

The address pointer is visible at all times, so the read path can continue from it after a commit.

Top module: `pgc_top`

## Requirements
- R1: After reset, busy_o, arr_we_o and cur_addr_o are all 0.
- R2: An accepted load_i sets cur_addr_o to load_addr_i. Each accepted byte_i adds 1 to the low 7 bits of cur_addr_o while the upper 9 bits stay unchanged, so offset 127 is followed by offset 0 of the same page.
- R3: When more than 128 bytes arrive before the end strobe, the byte received last for a given offset is the one committed.
- R4: arr_we_o stays 0 until an end strobe (stop_i) is accepted with at least one byte buffered. arr_we_o is then 1 for exactly one cycle, in the cycle after stop_i. In that cycle arr_page_o carries the upper 9 address bits, arr_mask_o bit i marks offset i, and arr_data_o bits [8i+7:8i] carry the data for offset i.
- R5: Offsets not received in the transaction have their mask bit clear, so the array keeps its old contents there.
- R6: stop_i with no byte buffered produces no array write and no busy window, and leaves cur_addr_o unchanged.
- R7: After a commit, busy_o is 1 from the cycle after stop_i for exactly PROG_CYCLES cycles.
- R8: While busy_o is 1, load_i, byte_i and stop_i are ignored: the pointer does not move, no byte is buffered and no commit starts.
- R9: A byte strobed while wp_i is 1 and cur_addr_o >= PROT_BASE is not buffered, but the pointer still advances. Below PROT_BASE, wp_i has no effect.
- R10: After a commit, cur_addr_o equals the address of the last received byte plus 1, wrapped within the page.
- R11: A byte_i in the same cycle as stop_i is included in that commit.
- R12: An accepted load_i discards bytes not yet committed. When load_i and byte_i are in the same cycle, the load wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load start address strobe |
| load_addr_i | input | 16 | Start address of the transaction |
| byte_i | input | 1 | Data byte strobe |
| byte_data_i | input | 8 | Data byte |
| stop_i | input | 1 | End-of-transaction strobe, starts the commit |
| wp_i | input | 1 | Write-protect level |
| busy_o | output | 1 | Programming window active |
| cur_addr_o | output | 16 | Internal address pointer |
| arr_we_o | output | 1 | Array page write request, one cycle |
| arr_page_o | output | 9 | Page index of the write |
| arr_mask_o | output | 128 | Per-offset write enable |
| arr_data_o | output | 1024 | Page data, offset i at bits [8i+7:8i] |

## Verification
The case of interest is a data byte strobe that falls in the same cycle as the end strobe. The byte must still be captured, and it must land inside the very commit that the same edge starts. The bench provokes this by driving byte_i and stop_i together, both with an otherwise empty buffer and after a partial page. It then compares the page the array received, and the final pointer, against its own model. In that model the byte is applied before the commit is taken.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic {
    PGC_IDLE = 1'b0,
    PGC_PROG = 1'b1
  } pgc_state_e;
endpackage

// File: rtl/pgc_addr_ptr.sv
module pgc_addr_ptr #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_addr_i;
    else if (step_i) ptr_q <= {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + 1'b1};
  end

  assign ptr_o = ptr_q;

  // page bits never move on a byte step
  assert_page_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ptr_q[ADDR_W-1:OFF_W] == $past(ptr_q[ADDR_W-1:OFF_W]));

  assert_offset_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ptr_q[OFF_W-1:0] == $past(ptr_q[OFF_W-1:0]) + 1'b1);
endmodule

// File: rtl/pgc_page_buf.sv
module pgc_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic [OFF_W-1:0]             wr_off_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [PAGE_BYTES-1:0]        valid_nxt_o,
  output logic [PAGE_BYTES*DATA_W-1:0] data_nxt_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic              hit;
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign hit = wr_i && (wr_off_i == OFF_W'(g));
    assign valid_nxt_o[g] = vld_q | hit;
    assign data_nxt_o[g*DATA_W +: DATA_W] = hit ? wr_data_i : dat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= 1'b0;
      else         vld_q <= clr_i ? 1'b0 : (vld_q | hit);
    end

    always_ff @(posedge clk_i) begin
      if (hit) dat_q <= wr_data_i;
    end

    // a cleared lane comes back empty
    assert_lane_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !vld_q);
  end
endmodule

// File: rtl/pgc_prog_timer.sv
module pgc_prog_timer
  import pgc_pkg::*;
#(
  parameter int PROG_CYCLES = 1250000,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  pgc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PGC_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PGC_IDLE: if (start_i) begin
          state_q <= PGC_PROG;
          cnt_q   <= CNT_W'(PROG_CYCLES - 1);
        end
        PGC_PROG: begin
          if (cnt_q == '0) state_q <= PGC_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= PGC_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == PGC_PROG);

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);

  assert_window_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/pgc_top.sv
module pgc_top #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          PAGE_BYTES  = 128,
  parameter int          PROG_CYCLES = 1250000,
  parameter int unsigned PROT_BASE   = 32'h8000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [ADDR_W-1:0]            load_addr_i,
  input  logic                         byte_i,
  input  logic [DATA_W-1:0]            byte_data_i,
  input  logic                         stop_i,
  input  logic                         wp_i,
  output logic                         busy_o,
  output logic [ADDR_W-1:0]            cur_addr_o,
  output logic                         arr_we_o,
  output logic [PAGE_W-1:0]            arr_page_o,
  output logic [PAGE_BYTES-1:0]        arr_mask_o,
  output logic [PAGE_BYTES*DATA_W-1:0] arr_data_o
);
  logic                         busy;
  logic [ADDR_W-1:0]            ptr;
  logic                         load_acc, byte_acc, stop_acc, prot, buf_wr, commit;
  logic [PAGE_BYTES-1:0]        valid_nxt;
  logic [PAGE_BYTES*DATA_W-1:0] data_nxt;
  logic                         we_q;
  logic [PAGE_W-1:0]            page_q;
  logic [PAGE_BYTES-1:0]        mask_q;
  logic [PAGE_BYTES*DATA_W-1:0] wdata_q;

  // all requests are dropped during programming; load beats a same-cycle byte
  assign load_acc = load_i && !busy;
  assign byte_acc = byte_i && !busy && !load_i;
  assign stop_acc = stop_i && !busy && !load_i;
  assign prot     = wp_i && (32'(ptr) >= PROT_BASE);
  assign buf_wr   = byte_acc && !prot;
  assign commit   = stop_acc && (|valid_nxt);

  pgc_addr_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_acc),
    .load_addr_i(load_addr_i),
    .step_i     (byte_acc),
    .ptr_o      (ptr)
  );

  pgc_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (load_acc || commit),
    .wr_i       (buf_wr),
    .wr_off_i   (ptr[OFF_W-1:0]),
    .wr_data_i  (byte_data_i),
    .valid_nxt_o(valid_nxt),
    .data_nxt_o (data_nxt)
  );

  pgc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      page_q <= '0;
      mask_q <= '0;
    end else begin
      we_q <= commit;
      if (commit) begin
        page_q <= ptr[ADDR_W-1:OFF_W];
        mask_q <= valid_nxt;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit) wdata_q <= data_nxt;
  end

  assign busy_o     = busy;
  assign cur_addr_o = ptr;
  assign arr_we_o   = we_q;
  assign arr_page_o = page_q;
  assign arr_mask_o = mask_q;
  assign arr_data_o = wdata_q;

  assert_one_shot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |=> !arr_we_o);

  assert_we_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  assert_no_empty_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> (arr_mask_o != '0));

  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cur_addr_o));

  assert_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> arr_we_o);
endmodule

// File: tb/pgc_top_tb.sv
module pgc_top_tb;
  localparam int          AW   = 16;
  localparam int          PG   = 128;
  localparam int          PROG = 40;
  localparam int unsigned PB   = 32'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           load_i = 0, byte_i = 0, stop_i = 0, wp_i = 0;
  logic [AW-1:0]  load_addr_i = '0;
  logic [7:0]     byte_data_i = '0;
  logic           busy_o, arr_we_o;
  logic [AW-1:0]  cur_addr_o;
  logic [8:0]     arr_page_o;
  logic [PG-1:0]  arr_mask_o;
  logic [PG*8-1:0] arr_data_o;

  pgc_top #(.PROG_CYCLES(PROG), .PROT_BASE(PB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
    .byte_i(byte_i), .byte_data_i(byte_data_i), .stop_i(stop_i), .wp_i(wp_i),
    .busy_o(busy_o), .cur_addr_o(cur_addr_o), .arr_we_o(arr_we_o),
    .arr_page_o(arr_page_o), .arr_mask_o(arr_mask_o), .arr_data_o(arr_data_o)
  );

  logic [7:0]    ram  [int];
  logic [7:0]    expm [int];
  logic [AW-1:0] mptr;
  logic [7:0]    mbuf [PG];
  bit            mval [PG];
  int n_chk = 0, n_bad = 0;

  // array model fed by the commit port
  always @(negedge clk)
    if (rst_n && arr_we_o)
      for (int i = 0; i < PG; i++)
        if (arr_mask_o[i]) ram[{arr_page_o, 7'(i)}] = arr_data_o[i*8 +: 8];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return {a[AW-1:7], a[6:0] + 7'd1};
  endfunction

  function automatic logic [7:0] rd(ref logic [7:0] m [int], input int a);
    return m.exists(a) ? m[a] : 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic bit m_any();
    for (int i = 0; i < PG; i++) if (mval[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < PG; i++) mval[i] = 1'b0;
  endtask

  task automatic m_byte(input logic [7:0] d, input bit wp);
    if (!(wp && 32'(mptr) >= PB)) begin
      mbuf[mptr[6:0]] = d;
      mval[mptr[6:0]] = 1'b1;
    end
    mptr = nxt(mptr);
  endtask

  task automatic t_load(input logic [AW-1:0] a);
    load_i = 1; load_addr_i = a;
    @(negedge clk);
    load_i = 0;
    mptr = a; m_clear();
    chk("R2", "load pointer", 32'(cur_addr_o), 32'(a));
  endtask

  task automatic t_byte(input logic [7:0] d, input bit wp);
    byte_i = 1; byte_data_i = d; wp_i = wp;
    @(negedge clk);
    byte_i = 0; wp_i = 0;
    m_byte(d, wp);
    chk("R2", "byte step pointer", 32'(cur_addr_o), 32'(mptr));
    chk("R4", "no write before stop", 32'(arr_we_o), 0);
  endtask

  // with_byte: byte in the stop cycle (R11); junk: requests during busy (R8)
  task automatic t_stop(input bit with_byte, input logic [7:0] d, input bit junk);
    bit any;
    int cnt;
    stop_i = 1;
    if (with_byte) begin byte_i = 1; byte_data_i = d; end
    @(negedge clk);
    stop_i = 0; byte_i = 0;
    if (with_byte) m_byte(d, 1'b0);
    any = m_any();
    if (any) begin
      for (int i = 0; i < PG; i++) if (mval[i]) expm[{mptr[AW-1:7], 7'(i)}] = mbuf[i];
      m_clear();
    end
    chk(any ? "R7" : "R6", "busy after stop", 32'(busy_o), 32'(any));
    chk(any ? "R4" : "R6", "write strobe after stop", 32'(arr_we_o), 32'(any));
    chk(any ? "R10" : "R6", "pointer after stop", 32'(cur_addr_o), 32'(mptr));
    if (any) begin
      cnt = 0;
      while (busy_o) begin
        cnt++;
        if (junk && cnt == 3) begin
          load_i = 1; load_addr_i = 16'h1234; byte_i = 1; byte_data_i = 8'hEE; stop_i = 1;
        end else begin
          load_i = 0; byte_i = 0; stop_i = 0;
        end
        @(negedge clk);
      end
      load_i = 0; byte_i = 0; stop_i = 0;
      chk("R7", "busy length", 32'(cnt), 32'(PROG));
      if (junk) chk("R8", "pointer after busy requests", 32'(cur_addr_o), 32'(mptr));
    end
  endtask

  task automatic chk_page(input logic [8:0] pg, input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < PG; i++)
      if (rd(ram, {pg, 7'(i)}) !== rd(expm, {pg, 7'(i)})) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(req, "page contents", 0, 0);
    else chk(req, $sformatf("page %0h offset %0d", pg, first),
             32'(rd(ram, {pg, 7'(first)})), 32'(rd(expm, {pg, 7'(first)})));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    mptr = '0; m_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy at reset", 32'(busy_o), 0);
    chk("R1", "write at reset", 32'(arr_we_o), 0);
    chk("R1", "pointer at reset", 32'(cur_addr_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R4 R10 plain write of 3 bytes mid page
    t_load(16'h0140);
    t_byte(8'hA1, 0); t_byte(8'hA2, 0); t_byte(8'hA3, 0);
    t_stop(0, 0, 0);
    chk_page(9'h002, "R4");

    // R5 partial overwrite keeps untouched offsets
    t_load(16'h0141);
    t_byte(8'hB2, 0);
    t_stop(0, 0, 0);
    chk_page(9'h002, "R5");

    // R2 R10 wrap from offset 127
    t_load(16'h037E);
    t_byte(8'h11, 0); t_byte(8'h22, 0); t_byte(8'h33, 0);
    chk("R2", "wrap stays in page", 32'(cur_addr_o), 32'h0301);
    t_stop(0, 0, 0);
    chk_page(9'h006, "R2");

    // R3 more than a page: 130 bytes from offset 0
    t_load(16'h0400);
    for (int i = 0; i < 130; i++) t_byte(8'(i + 5), 0);
    t_stop(0, 0, 0);
    chk_page(9'h008, "R3");

    // R6 dummy write: address only
    t_load(16'h0555);
    t_stop(0, 0, 0);
    chk("R6", "dummy keeps pointer", 32'(cur_addr_o), 32'h0555);

    // R11 byte with stop, empty buffer and partial buffer
    t_load(16'h0600);
    t_stop(1, 8'h5C, 0);
    chk_page(9'h00C, "R11");
    t_load(16'h0620);
    t_byte(8'h61, 0);
    t_stop(1, 8'h62, 0);
    chk_page(9'h00C, "R11");

    // R8 requests during busy are ignored, buffer stays empty
    t_load(16'h0700);
    t_byte(8'h71, 0);
    t_stop(0, 0, 1);
    t_stop(0, 0, 0);
    chk_page(9'h00E, "R8");
    chk_page(9'h024, "R8");

    // R9 protection: upper region blocked, lower region unaffected
    t_load(16'h8010);
    t_byte(8'h91, 1); t_byte(8'h92, 0);
    chk("R9", "pointer advances on blocked byte", 32'(cur_addr_o), 32'h8012);
    t_stop(0, 0, 0);
    chk_page(9'h100, "R9");
    t_load(16'h8050);
    t_byte(8'h93, 1);
    t_stop(0, 0, 0);
    chk("R9", "fully blocked page starts no window", 32'(busy_o), 0);
    t_load(16'h0810);
    t_byte(8'h94, 1);
    t_stop(0, 0, 0);
    chk_page(9'h010, "R9");

    // R12 reload discards, load beats byte
    t_load(16'h0900);
    t_byte(8'hC1, 0);
    t_load(16'h0980);
    t_stop(0, 0, 0);
    chk_page(9'h012, "R12");
    chk_page(9'h013, "R12");
    load_i = 1; load_addr_i = 16'h0A05; byte_i = 1; byte_data_i = 8'hD1;
    @(negedge clk);
    load_i = 0; byte_i = 0;
    mptr = 16'h0A05; m_clear();
    chk("R12", "load wins over byte", 32'(cur_addr_o), 32'h0A05);
    t_stop(0, 0, 0);

    // random transactions
    for (int t = 0; t < 24; t++) begin
      logic [AW-1:0] a;
      int n;
      bit bs;
      a = 16'($urandom);
      n = $urandom_range(0, 140);
      t_load(a);
      for (int i = 0; i < n; i++) t_byte(8'($urandom), ($urandom_range(0, 4) == 0));
      bs = ($urandom_range(0, 3) == 0);
      t_stop(bs, 8'($urandom), 0);
      chk_page(a[AW-1:7], "R3");
    end

    summary();
  end
endmodule